// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller. Each request arrives as a kind code, a byte address, a byte length and an access mode. In the same cycle the block answers with one status: issued, aliased, full, conditional-store failed or malformed. When a request is issued, the block sends a request class, the line address and a privilege bit downstream in that same cycle.

An accepted request is stored in one of two small fully associative tables, a read table or a write table, chosen by its kind. The entry is keyed by line address and records the cycle in which it was issued. A completion port takes a line address and a table selector. It retires the matching entry and reports the miss latency.

The block also keeps a single-line reservation for load-linked / store-conditional pairs. It has two sticky error flags: one for an entry that has stayed outstanding too long, and one for a completion that matches no entry.

Top module: `missTracker`

## Requirements
- R1: Request kinds are encoded as load=0, fetch=1, store=2, rmw-read=3, rmw-write=4, locked-read=5, locked-write=6. Kinds 2 to 6 allocate in the write table and kinds 0 and 1 allocate in the read table, so a completion succeeds only when `cmpIsWrite` selects that table.
- R2: When the request's line (address with the low log2(LINE_BYTES) bits cleared) matches a valid entry in either table, `reqStatus` is 2 (aliased) and nothing is allocated.
- R3: When there is no alias and `outCount` is at least MAX_OUT, `reqStatus` is 3 (full) and nothing is allocated.
- R4: A locked-write is issued only if the reservation is held for its own line, and issuing it clears the reservation. Otherwise `reqStatus` is 4 (store-conditional failed), nothing is allocated and nothing goes downstream.
- R5: When a locked-read entry retires from the write table, the reservation is set on its line.
- R6: When offset-in-line plus length is greater than LINE_BYTES, or the kind code is 7, `reqStatus` is 5 (malformed). This check takes priority over every other status. A request that raises no refusal gives status 1 (issued), and status 0 means no request is present.
- R7: `outCount` always equals the number of valid read entries plus the number of valid write entries. It rises one cycle after each allocation and falls one cycle after each retirement.
- R8: `deadlockErr` becomes set and stays set once any valid entry's age (current cycle minus issue cycle) reaches DEADLOCK. It is registered, so it shows one cycle after the age first equals DEADLOCK.
- R9: A completion that hits an entry raises `cmpDone` in the same cycle. `cmpLatency` is the number of cycles from the allocation cycle to the completion cycle, and `cmpMiss` is high when that latency is non-zero.
- R10: The downstream class `dnClass` is fetch=0, load=1, store=2, and atomic=3 for kinds 3 to 6. `dnMode` is 1 only for access mode 1 (supervisor); modes 0 (user) and 2 (device) are sent as 0.
- R11: A completion that matches no valid entry in the selected table sets the sticky `protoErr` on the next cycle and leaves `outCount` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqType | input | 3 | Request kind code |
| reqAddr | input | ADDR_W | Byte address |
| reqLen | input | LEN_W | Byte length |
| reqMode | input | 2 | Access mode: 0 user, 1 supervisor, 2 device |
| reqStatus | output | 3 | Same-cycle answer to the request |
| dnValid | output | 1 | Downstream request strobe |
| dnClass | output | 2 | Downstream request class |
| dnLine | output | ADDR_W | Downstream line address |
| dnMode | output | 1 | Downstream privilege bit |
| cmpValid | input | 1 | Completion present this cycle |
| cmpLine | input | ADDR_W | Completed line address |
| cmpIsWrite | input | 1 | Completion targets the write table |
| cmpDone | output | 1 | Completion matched an entry |
| cmpLatency | output | CYC_W | Cycles the entry was outstanding |
| cmpMiss | output | 1 | Latency is non-zero |
| outCount | output | CNT_W | Number of outstanding entries |
| deadlockErr | output | 1 | Sticky entry-age alarm |
| protoErr | output | 1 | Sticky unmatched-completion flag |

## Verification
The request status, the downstream fields and the completion outputs are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. The effects on the tables, the count and the reservation show one rising edge later, and the bench reads them at the following falling edge. The age alarm is due exactly DEADLOCK rising edges after the allocation edge, and the bench checks it both one edge before that and on that edge. Expected latencies come from a cycle counter in the bench that records the cycle in which each request was driven.

// File: rtl/missTrackerPkg.sv
package missTrackerPkg;

  typedef enum logic [2:0] {
    KIND_LOAD    = 3'd0,
    KIND_FETCH   = 3'd1,
    KIND_STORE   = 3'd2,
    KIND_RMW_RD  = 3'd3,
    KIND_RMW_WR  = 3'd4,
    KIND_LOCK_RD = 3'd5,
    KIND_LOCK_WR = 3'd6,
    KIND_BAD     = 3'd7
  } reqKind_e;

  typedef enum logic [2:0] {
    ANS_NONE   = 3'd0,
    ANS_ISSUED = 3'd1,
    ANS_ALIAS  = 3'd2,
    ANS_FULL   = 3'd3,
    ANS_SCFAIL = 3'd4,
    ANS_BAD    = 3'd5
  } reqAns_e;

  typedef enum logic [1:0] {
    CLS_FETCH  = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_ATOMIC = 2'd3
  } dnClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic allocWr;
    logic allocLock;
    logic clrResv;
    logic retire;
    logic setResv;
    logic flagProto;
  } strobe_t;

endpackage

// File: rtl/missTrackerTable.sv
module missTrackerTable #(
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 8,
  parameter int CYC_W    = 16,
  parameter int DEADLOCK = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CYC_W-1:0]  nowCycle,
  input  logic [ADDR_W-1:0] lookLine,
  output logic              lookHit,
  input  logic              allocEn,
  input  logic              allocLock,
  input  logic [ADDR_W-1:0] allocLine,
  input  logic              retEn,
  input  logic [ADDR_W-1:0] retLine,
  output logic              retHit,
  output logic              retLock,
  output logic [CYC_W-1:0]  retIssue,
  output logic              agedAny,
  output logic [ENTRIES-1:0] validVec
);

  logic [ENTRIES-1:0] valid;
  logic [ADDR_W-1:0]  tag   [ENTRIES];
  logic [CYC_W-1:0]   issue [ENTRIES];
  logic [ENTRIES-1:0] lockFlag;
  logic [ENTRIES-1:0] lookMatch, retMatch, aged, freeOh;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
      logic [CYC_W-1:0] age;
      assign lookMatch[i] = valid[i] && (tag[i] == lookLine);
      assign retMatch[i]  = valid[i] && (tag[i] == retLine);
      assign age          = nowCycle - issue[i];
      assign aged[i]      = valid[i] && (age >= CYC_W'(DEADLOCK));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          valid[i]    <= 1'b0;
          tag[i]      <= '0;
          issue[i]    <= '0;
          lockFlag[i] <= 1'b0;
        end else if (allocEn && freeOh[i]) begin
          valid[i]    <= 1'b1;
          tag[i]      <= allocLine;
          issue[i]    <= nowCycle;
          lockFlag[i] <= allocLock;
        end else if (retEn && retMatch[i]) begin
          valid[i] <= 1'b0;
        end
      end
    end
  endgenerate

  // first free slot, one-hot
  always_comb begin
    logic found;
    found  = 1'b0;
    freeOh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !found) begin
        freeOh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  // at most one entry matches a line, so an OR mux suffices
  always_comb begin
    retIssue = '0;
    retLock  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (retMatch[i]) begin
        retIssue = retIssue | issue[i];
        retLock  = retLock | lockFlag[i];
      end
    end
  end

  assign lookHit  = |lookMatch;
  assign retHit   = |retMatch;
  assign agedAny  = |aged;
  assign validVec = valid;

endmodule

// File: rtl/missTrackerData.sv
module missTrackerData
  import missTrackerPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 8,
  parameter int CYC_W    = 16,
  parameter int DEADLOCK = 1000,
  parameter int CNT_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  reqLine,
  input  logic [ADDR_W-1:0]  cmpLine,
  input  logic               cmpIsWrite,
  output logic               reqHit,
  output logic               resvHit,
  output logic               cmpHit,
  output logic               cmpLock,
  output logic [CYC_W-1:0]   cmpLatency,
  output logic [CNT_W-1:0]   outCount,
  output logic               deadlockErr,
  output logic               protoErr,
  output logic [ENTRIES-1:0] rdValid,
  output logic [ENTRIES-1:0] wrValid
);

  logic [CYC_W-1:0]  nowCycle;
  logic [ADDR_W-1:0] resvLine;
  logic              resvValid;

  logic rdLookHit, wrLookHit, rdRetHit, wrRetHit, rdRetLock, wrRetLock;
  logic rdAged, wrAged;
  logic [CYC_W-1:0] rdIssue, wrIssue;

  missTrackerTable #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CYC_W(CYC_W), .DEADLOCK(DEADLOCK)) u_rdTab (
    .clk(clk), .rstN(rstN), .nowCycle(nowCycle),
    .lookLine(reqLine), .lookHit(rdLookHit),
    .allocEn(stb.alloc && !stb.allocWr), .allocLock(1'b0), .allocLine(reqLine),
    .retEn(stb.retire && !cmpIsWrite), .retLine(cmpLine),
    .retHit(rdRetHit), .retLock(rdRetLock), .retIssue(rdIssue),
    .agedAny(rdAged), .validVec(rdValid)
  );

  missTrackerTable #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CYC_W(CYC_W), .DEADLOCK(DEADLOCK)) u_wrTab (
    .clk(clk), .rstN(rstN), .nowCycle(nowCycle),
    .lookLine(reqLine), .lookHit(wrLookHit),
    .allocEn(stb.alloc && stb.allocWr), .allocLock(stb.allocLock), .allocLine(reqLine),
    .retEn(stb.retire && cmpIsWrite), .retLine(cmpLine),
    .retHit(wrRetHit), .retLock(wrRetLock), .retIssue(wrIssue),
    .agedAny(wrAged), .validVec(wrValid)
  );

  assign reqHit     = rdLookHit || wrLookHit;
  assign resvHit    = resvValid && (resvLine == reqLine);
  assign cmpHit     = cmpIsWrite ? wrRetHit : rdRetHit;
  assign cmpLock    = cmpIsWrite && wrRetLock;
  assign cmpLatency = nowCycle - (cmpIsWrite ? wrIssue : rdIssue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowCycle    <= '0;
      outCount    <= '0;
      resvValid   <= 1'b0;
      resvLine    <= '0;
      deadlockErr <= 1'b0;
      protoErr    <= 1'b0;
    end else begin
      nowCycle <= nowCycle + 1'b1;
      outCount <= outCount + CNT_W'(stb.alloc) - CNT_W'(stb.retire);
      if (stb.setResv) begin
        resvValid <= 1'b1;
        resvLine  <= cmpLine;
      end else if (stb.clrResv) begin
        resvValid <= 1'b0;
      end
      if (rdAged || wrAged) deadlockErr <= 1'b1;
      if (stb.flagProto)    protoErr    <= 1'b1;
    end
  end

endmodule

// File: rtl/missTrackerCtrl.sv
module missTrackerCtrl
  import missTrackerPkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int MAX_OUT    = 8,
  parameter int CNT_W      = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = OFF_W + 1
) (
  input  logic             reqValid,
  input  logic [2:0]       reqType,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [1:0]       reqMode,
  input  logic             reqHit,
  input  logic             resvHit,
  input  logic [CNT_W-1:0] outCount,
  input  logic             cmpValid,
  input  logic             cmpHit,
  input  logic             cmpLock,
  output logic [2:0]       reqStatus,
  output logic             dnValid,
  output logic [1:0]       dnClass,
  output logic             dnMode,
  output strobe_t          stb
);

  reqKind_e kind;
  reqAns_e  ans;
  logic     toWrite, lenBad;
  logic [LEN_W:0] reach;

  assign kind    = reqKind_e'(reqType);
  assign toWrite = (kind != KIND_LOAD) && (kind != KIND_FETCH);
  assign reach   = {1'b0, LEN_W'(reqOffset)} + {1'b0, reqLen};
  assign lenBad  = (reach > (LEN_W+1)'(LINE_BYTES)) || (kind == KIND_BAD);

  always_comb begin
    if (!reqValid)                                ans = ANS_NONE;
    else if (lenBad)                              ans = ANS_BAD;
    else if (reqHit)                              ans = ANS_ALIAS;
    else if (outCount >= CNT_W'(MAX_OUT))         ans = ANS_FULL;
    else if (kind == KIND_LOCK_WR && !resvHit)    ans = ANS_SCFAIL;
    else                                          ans = ANS_ISSUED;
  end

  always_comb begin
    unique case (kind)
      KIND_FETCH: dnClass = CLS_FETCH;
      KIND_LOAD:  dnClass = CLS_LOAD;
      KIND_STORE: dnClass = CLS_STORE;
      default:    dnClass = CLS_ATOMIC;
    endcase
  end

  assign reqStatus = ans;
  assign dnValid   = (ans == ANS_ISSUED);
  assign dnMode    = (reqMode == 2'd1);

  always_comb begin
    stb           = '0;
    stb.alloc     = dnValid;
    stb.allocWr   = toWrite;
    stb.allocLock = (kind == KIND_LOCK_RD);
    stb.clrResv   = dnValid && (kind == KIND_LOCK_WR);
    stb.retire    = cmpValid && cmpHit;
    stb.setResv   = cmpValid && cmpHit && cmpLock;
    stb.flagProto = cmpValid && !cmpHit;
  end

endmodule

// File: rtl/missTracker.sv
module missTracker
  import missTrackerPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int ENTRIES    = 8,
  parameter int MAX_OUT    = 8,
  parameter int CYC_W      = 16,
  parameter int DEADLOCK   = 1000,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = OFF_W + 1,
  localparam int CNT_W     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [1:0]        reqMode,
  output logic [2:0]        reqStatus,
  output logic              dnValid,
  output logic [1:0]        dnClass,
  output logic [ADDR_W-1:0] dnLine,
  output logic              dnMode,
  input  logic              cmpValid,
  input  logic [ADDR_W-1:0] cmpLine,
  input  logic              cmpIsWrite,
  output logic              cmpDone,
  output logic [CYC_W-1:0]  cmpLatency,
  output logic              cmpMiss,
  output logic [CNT_W-1:0]  outCount,
  output logic              deadlockErr,
  output logic              protoErr
);

  strobe_t            stb;
  logic [ADDR_W-1:0]  reqLineAddr, cmpLineAddr;
  logic               reqHit, resvHit, cmpHit, cmpLock;
  logic [ENTRIES-1:0] rdValid, wrValid;

  assign reqLineAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign cmpLineAddr = {cmpLine[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  missTrackerCtrl #(.LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_ctrl (
    .reqValid(reqValid), .reqType(reqType), .reqOffset(reqAddr[OFF_W-1:0]),
    .reqLen(reqLen), .reqMode(reqMode), .reqHit(reqHit), .resvHit(resvHit),
    .outCount(outCount), .cmpValid(cmpValid), .cmpHit(cmpHit), .cmpLock(cmpLock),
    .reqStatus(reqStatus), .dnValid(dnValid), .dnClass(dnClass), .dnMode(dnMode),
    .stb(stb)
  );

  missTrackerData #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CYC_W(CYC_W),
                    .DEADLOCK(DEADLOCK), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .reqLine(reqLineAddr), .cmpLine(cmpLineAddr),
    .cmpIsWrite(cmpIsWrite), .reqHit(reqHit), .resvHit(resvHit), .cmpHit(cmpHit),
    .cmpLock(cmpLock), .cmpLatency(cmpLatency), .outCount(outCount),
    .deadlockErr(deadlockErr), .protoErr(protoErr), .rdValid(rdValid), .wrValid(wrValid)
  );

  assign dnLine  = reqLineAddr;
  assign cmpDone = cmpValid && cmpHit;
  assign cmpMiss = cmpDone && (cmpLatency != '0);

endmodule

// File: rtl/missTrackerChecker.sv
module missTrackerChecker #(
  parameter int ENTRIES = 8,
  parameter int MAX_OUT = 8,
  parameter int CNT_W   = 4,
  parameter int CYC_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [2:0]         reqStatus,
  input logic               dnValid,
  input logic               cmpDone,
  input logic [CYC_W-1:0]   cmpLatency,
  input logic [CNT_W-1:0]   outCount,
  input logic [ENTRIES-1:0] rdValid,
  input logic [ENTRIES-1:0] wrValid,
  input logic               deadlockErr,
  input logic               protoErr
);

  a_r7_count_matches: assert property (@(posedge clk) disable iff (!rstN)
    int'(outCount) == $countones(rdValid) + $countones(wrValid));

  a_r3_never_over_max: assert property (@(posedge clk) disable iff (!rstN)
    int'(outCount) <= MAX_OUT);

  // R2 R3 R4: a refused request allocates nothing
  a_r2_refused_no_alloc: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStatus != 3'd1 && !cmpDone) |=> $stable(outCount));

  a_r4_scfail_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqStatus == 3'd4) |-> !dnValid);

  a_r10_dn_only_on_issue: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> (reqValid && reqStatus == 3'd1));

  a_r9_latency_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    cmpDone |-> (cmpLatency != '0));

  a_r8_deadlock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    deadlockErr |=> deadlockErr);

  a_r11_proto_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

endmodule

bind missTracker missTrackerChecker #(
  .ENTRIES(ENTRIES), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .CYC_W(CYC_W)
) u_missTrackerChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStatus(reqStatus),
  .dnValid(dnValid), .cmpDone(cmpDone), .cmpLatency(cmpLatency),
  .outCount(outCount), .rdValid(rdValid), .wrValid(wrValid),
  .deadlockErr(deadlockErr), .protoErr(protoErr)
);

// File: tb/missTracker_bench.sv
`timescale 1ns/1ps
module missTracker_bench;

  localparam int ADDR_W = 12, LINE_BYTES = 16, ENTRIES = 4, MAX_OUT = 3;
  localparam int CYC_W = 12, DEADLOCK = 40;
  localparam int LEN_W = 5, CNT_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqType = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [1:0] reqMode = '0;
  logic [2:0] reqStatus;
  logic dnValid, dnMode, cmpDone, cmpMiss, deadlockErr, protoErr;
  logic [1:0] dnClass;
  logic [ADDR_W-1:0] dnLine;
  logic cmpValid = 1'b0, cmpIsWrite = 1'b0;
  logic [ADDR_W-1:0] cmpLine = '0;
  logic [CYC_W-1:0] cmpLatency;
  logic [CNT_W-1:0] outCount;

  int total = 0, bad = 0, cyc = 0;
  int issueCyc [int];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  missTracker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ENTRIES(ENTRIES),
                .MAX_OUT(MAX_OUT), .CYC_W(CYC_W), .DEADLOCK(DEADLOCK)) u_missTracker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqMode(reqMode), .reqStatus(reqStatus), .dnValid(dnValid),
    .dnClass(dnClass), .dnLine(dnLine), .dnMode(dnMode), .cmpValid(cmpValid),
    .cmpLine(cmpLine), .cmpIsWrite(cmpIsWrite), .cmpDone(cmpDone),
    .cmpLatency(cmpLatency), .cmpMiss(cmpMiss), .outCount(outCount),
    .deadlockErr(deadlockErr), .protoErr(protoErr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int expClass(input int k);
    case (k)
      0: return 1;
      1: return 0;
      2: return 2;
      default: return 3;
    endcase
  endfunction

  // one request; status and downstream checked in the same cycle
  task automatic sendReq(input int k, input int addr, input int len, input int mode,
                         input int expSt, input string rq);
    @(negedge clk);
    reqValid = 1'b1; reqType = 3'(k); reqAddr = ADDR_W'(addr);
    reqLen = LEN_W'(len); reqMode = 2'(mode);
    #1;
    chk(reqStatus == 3'(expSt), rq, reqStatus, expSt);
    if (expSt == 1) begin
      issueCyc[addr & ~(LINE_BYTES-1)] = cyc;
      chk(dnValid && dnClass == 2'(expClass(k)), {rq, " R10 class"}, dnClass, expClass(k));
      chk(dnMode == (mode == 1), {rq, " R10 mode"}, dnMode, mode == 1);
      chk(dnLine == ADDR_W'(addr & ~(LINE_BYTES-1)), {rq, " line"}, dnLine,
          addr & ~(LINE_BYTES-1));
    end else begin
      chk(!dnValid, {rq, " no downstream"}, dnValid, 0);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic sendCmp(input int line, input bit isWr, input bit expHit, input string rq);
    int lat;
    @(negedge clk);
    cmpValid = 1'b1; cmpLine = ADDR_W'(line); cmpIsWrite = isWr;
    #1;
    chk(cmpDone == expHit, rq, cmpDone, expHit);
    if (expHit) begin
      lat = cyc - issueCyc[line];
      chk(int'(cmpLatency) == lat, {rq, " R9 latency"}, cmpLatency, lat);
      chk(cmpMiss == (lat != 0), {rq, " R9 miss"}, cmpMiss, lat != 0);
    end
    @(negedge clk);
    cmpValid = 1'b0;
  endtask

  task automatic expCount(input int n, input string rq);
    chk(int'(outCount) == n, {rq, " R7 count"}, outCount, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(outCount == 0, "reset count R7", outCount, 0);
    chk(reqStatus == 3'd0, "reset status R6", reqStatus, 0);
    chk(!deadlockErr && !protoErr, "reset flags R8 R11", {deadlockErr, protoErr}, 0);

    // R1 R10: every kind routes to its table, with a varying wait
    for (int k = 0; k <= 5; k++) begin
      int ln = 'h100 + k * LINE_BYTES;
      sendReq(k, ln + 4, 4, k % 3, 1, "R1 issue");
      expCount(1, "R1");
      repeat (k) @(negedge clk);
      sendCmp(ln, (k >= 2), 1'b1, "R1 retire");
      expCount(0, "R1");
    end

    // R2: aliasing across and within the tables
    sendReq(0, 'h200, 4, 0, 1, "R2 load");
    sendReq(2, 'h208, 4, 0, 2, "R2 store alias");
    sendReq(0, 'h20c, 2, 0, 2, "R2 load alias");
    expCount(1, "R2");
    sendReq(2, 'h300, 4, 0, 1, "R2 store");
    sendReq(1, 'h304, 4, 0, 2, "R2 fetch alias");
    expCount(2, "R2");

    // R3: full, with alias taking priority
    sendReq(3, 'h400, 4, 1, 1, "R3 third");
    expCount(3, "R3");
    sendReq(0, 'h500, 4, 0, 3, "R3 full");
    sendReq(0, 'h204, 4, 0, 2, "R3 alias beats full");
    expCount(3, "R3");
    sendCmp('h200, 1'b0, 1'b1, "R3 drain");
    sendCmp('h300, 1'b1, 1'b1, "R3 drain");
    sendCmp('h400, 1'b1, 1'b1, "R3 drain");
    expCount(0, "R3");

    // R4 R5: reservation handling
    sendReq(6, 'h600, 4, 0, 4, "R4 no reservation");
    expCount(0, "R4");
    sendReq(5, 'h600, 4, 0, 1, "R5 locked read");
    sendCmp('h600, 1'b1, 1'b1, "R5 locked read done");
    sendReq(6, 'h700, 4, 0, 4, "R4 other line");
    sendReq(6, 'h604, 4, 2, 1, "R4 reserved line");
    expCount(1, "R4");
    sendCmp('h600, 1'b1, 1'b1, "R4 write done");
    sendReq(6, 'h600, 4, 0, 4, "R4 reservation cleared");
    expCount(0, "R4");

    // R6: offset by length sweep, mode sweep for R10
    for (int off = 0; off < LINE_BYTES; off++) begin
      for (int len = 0; len <= LINE_BYTES; len++) begin
        if (off + len > LINE_BYTES) begin
          sendReq(0, 'h800 + off, len, (off + len) % 3, 5, "R6 malformed");
        end else begin
          sendReq(0, 'h800 + off, len, (off + len) % 3, 1, "R6 fits");
          sendCmp('h800, 1'b0, 1'b1, "R6 retire");
        end
      end
    end
    sendReq(7, 'h900, 4, 0, 5, "R6 bad kind");
    expCount(0, "R6");

    // R11: unmatched and wrong-table completions
    sendCmp('ha00, 1'b0, 1'b0, "R11 no entry");
    chk(protoErr, "R11 flag", protoErr, 1);
    sendReq(0, 'ha00, 4, 0, 1, "R11 load");
    sendCmp('ha00, 1'b1, 1'b0, "R11 wrong table");
    expCount(1, "R11");
    sendCmp('ha00, 1'b0, 1'b1, "R11 right table");
    expCount(0, "R11");

    // R8: age alarm exactly DEADLOCK edges after the allocation edge
    chk(!deadlockErr, "R8 before", deadlockErr, 0);
    sendReq(2, 'hb00, 4, 0, 1, "R8 store");
    repeat (DEADLOCK - 1) @(negedge clk);
    chk(!deadlockErr, "R8 one short", deadlockErr, 0);
    @(negedge clk);
    chk(deadlockErr, "R8 reached", deadlockErr, 1);
    sendCmp('hb00, 1'b1, 1'b1, "R8 retire");
    chk(deadlockErr, "R8 sticky", deadlockErr, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule